// File: doc/BRIEF.md
# Serial Key-State Link

This block moves a set of thirty on/off key levels from one side of a cable to the other over three signals: a shift clock, a load/latch strobe and one serial data line. A free-running frame sequencer counts through a fixed 34-clock frame. In the first 32 states the transmit shift register sends one bit per clock to the receive shift register. In the two closing states the strobe is high. The strobe reloads the transmit register from the synchronised key inputs. On its first clock it also copies the just-received word into a held output register.

Both sides run from the same clock, which is the link's shift clock. The key inputs are asynchronous to that clock, so each one passes through a two-flop synchroniser before it is captured. The outputs are plain levels with no handshake: a consumer reads `keys_out` at any time and always sees the last complete frame, never a word that is still being shifted. No back-pressure exists. The link repeats every 34 clocks whether or not anything has changed.

Top module: `keylink_top`

## Requirements
- R1: The frame is 34 clocks long. The sequencer counts states 0 to 33, and after state 33 it restarts at state 0, so the strobe falls exactly once every 34 clocks.
- R2: `link_latch` is high for exactly two consecutive clocks (states 32 and 33) and low for the 32 shift states. `link_load_n` is always its inverse.
- R3: During shift state p (0 to 31), `link_data` carries frame position p, and exactly one position is sent per clock, most significant first. Position p for p < 30 carries key (29 − p): key 29 is sent first and key 0 at position 29.
- R4: Frame positions 30 and 31 are padding and are always transmitted as 0.
- R5: `keys_out` changes only at the clock edge that ends state 32. It then takes the 30 key bits received in states 0 to 31 of that frame. It holds its value through every other clock, including when `keys_in` changes mid-frame.
- R6: A key level applied before state 31 of a frame and then held steady is carried in the next frame. It appears on `keys_out` at the end of that next frame's state 32.
- R7: A synchronous active-high reset clears the counter, both shift registers, the synchroniser and `keys_out` to zero. After reset is released the first state is 0, so the strobe first rises 32 clocks later. The first frame carries all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared shift clock for sequencer, transmitter and receiver |
| rst | input | 1 | Synchronous active-high reset |
| keys_in | input | 30 | Asynchronous key levels, bit n is key n |
| keys_out | output | 30 | Held key levels of the last complete frame, bit n is key n |
| link_load_n | output | 1 | Active-low transmit load, inverse of the strobe |
| link_latch | output | 1 | Active-high receive latch strobe (states 32 and 33) |
| link_data | output | 1 | Serial data line, MSB first |

## Verification
A counter that drifts from the 0–33 cycle shows at once on `link_latch`: the strobe is too long, too short, or falls at the wrong spacing within one frame. A transmit register that is wrong or shifts badly puts a wrong bit on `link_data` in the state where it occurs. That bit reaches `keys_out` at the end of the same frame, at most 34 clocks later. A receive word that leaks before the latch shows as a `keys_out` change in a shift state, on the very clock it happens. The sweep drives every single-key pattern plus dense patterns, so a swapped or stuck bit position is seen within one pattern.

// File: rtl/keylink_pkg.sv
package keylink_pkg;

  // Default geometry of the link.
  localparam int KEYS_DEF  = 30;
  localparam int FRAME_DEF = 32;

  // Per-state control decoded from the frame counter.
  typedef struct packed {
    logic shift_en;  // states 0 .. FRAME-1
    logic strobe;    // states FRAME and FRAME+1
    logic wrap;      // final state of the frame
  } seq_ctl_t;

endpackage

// File: rtl/keylink_sync.sv
module keylink_sync #(
  parameter int WIDTH  = 30,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg_q[s] <= '0;
          else     stg_q[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg_q[s] <= '0;
          else     stg_q[s] <= stg_q[s-1];
        end
      end
    end
  endgenerate

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/keylink_seq.sv
module keylink_seq
  import keylink_pkg::*;
#(
  parameter int FRAME_BITS = 32   // must be a power of two
) (
  input  logic                               clk,
  input  logic                               rst,
  output seq_ctl_t                           ctl,
  output logic [$clog2(FRAME_BITS):0]        state
);

  localparam int CNT_W = $clog2(FRAME_BITS) + 1;
  localparam int LAST  = FRAME_BITS + 1;

  logic [CNT_W-1:0] cnt_q;

  // Top bit marks the strobe states; top bit with bit 0 marks the last one.
  assign ctl.strobe   = cnt_q[CNT_W-1];
  assign ctl.shift_en = ~cnt_q[CNT_W-1];
  assign ctl.wrap     = cnt_q[CNT_W-1] & cnt_q[0];
  assign state        = cnt_q;

  always_ff @(posedge clk) begin
    if (rst)           cnt_q <= '0;
    else if (ctl.wrap) cnt_q <= '0;
    else               cnt_q <= cnt_q + CNT_W'(1);
  end

  assert_count_bound_R1: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(LAST));

  assert_restart_R1: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == CNT_W'(LAST)) |=> (cnt_q == '0));

  assert_strobe_pair_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(ctl.strobe) |=> ctl.strobe);

endmodule

// File: rtl/keylink_tx.sv
module keylink_tx #(
  parameter int KEYS       = 30,
  parameter int FRAME_BITS = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load_n,
  input  logic            shift_en,
  input  logic [KEYS-1:0] keys,
  output logic            sdata
);

  localparam int PAD = FRAME_BITS - KEYS;

  logic [FRAME_BITS-1:0] sr_q;

  always_ff @(posedge clk) begin
    if (rst)           sr_q <= '0;
    else if (!load_n)  sr_q <= {keys, {PAD{1'b0}}};
    else if (shift_en) sr_q <= {sr_q[FRAME_BITS-2:0], 1'b0};
  end

  assign sdata = sr_q[FRAME_BITS-1];

  // A shift always moves the next bit up to the line.
  assert_shift_step_R3: assert property (@(posedge clk) disable iff (rst)
    (load_n && shift_en) |=> (sdata == $past(sr_q[FRAME_BITS-2])));

endmodule

// File: rtl/keylink_rx.sv
module keylink_rx #(
  parameter int KEYS       = 30,
  parameter int FRAME_BITS = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            shift_en,
  input  logic            latch,
  input  logic            sdata,
  output logic [KEYS-1:0] keys_out
);

  localparam int PAD = FRAME_BITS - KEYS;

  logic [FRAME_BITS-1:0] sr_q;
  logic [KEYS-1:0]       out_q;

  always_ff @(posedge clk) begin
    if (rst)           sr_q <= '0;
    else if (shift_en) sr_q <= {sr_q[FRAME_BITS-2:0], sdata};
  end

  // Padding sits in the low positions and is dropped here.
  always_ff @(posedge clk) begin
    if (rst)        out_q <= '0;
    else if (latch) out_q <= sr_q[FRAME_BITS-1:PAD];
  end

  assign keys_out = out_q;

  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !latch |=> $stable(out_q));

  assert_idle_shift_R3: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(sr_q));

endmodule

// File: rtl/keylink_top.sv
module keylink_top
  import keylink_pkg::*;
#(
  parameter int KEYS        = KEYS_DEF,
  parameter int FRAME_BITS  = FRAME_DEF,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [KEYS-1:0] keys_in,
  output logic [KEYS-1:0] keys_out,
  output logic            link_load_n,
  output logic            link_latch,
  output logic            link_data
);

  localparam int CNT_W = $clog2(FRAME_BITS) + 1;

  seq_ctl_t         ctl;
  logic [CNT_W-1:0] state;
  logic [KEYS-1:0]  keys_sync;

  keylink_sync #(.WIDTH(KEYS), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk), .rst (rst), .d (keys_in), .q (keys_sync)
  );

  keylink_seq #(.FRAME_BITS(FRAME_BITS)) u_seq (
    .clk (clk), .rst (rst), .ctl (ctl), .state (state)
  );

  assign link_latch  = ctl.strobe;
  assign link_load_n = ~ctl.strobe;

  keylink_tx #(.KEYS(KEYS), .FRAME_BITS(FRAME_BITS)) u_tx (
    .clk (clk), .rst (rst), .load_n (link_load_n), .shift_en (ctl.shift_en),
    .keys (keys_sync), .sdata (link_data)
  );

  keylink_rx #(.KEYS(KEYS), .FRAME_BITS(FRAME_BITS)) u_rx (
    .clk (clk), .rst (rst), .shift_en (ctl.shift_en), .latch (link_latch),
    .sdata (link_data), .keys_out (keys_out)
  );

  assert_pad_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (state >= CNT_W'(KEYS) && state < CNT_W'(FRAME_BITS)) |-> !link_data);

  assert_frame_start_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(link_latch) |-> (state == '0));

  assert_load_inverse_R2: assert property (@(posedge clk) disable iff (rst)
    link_load_n != link_latch);

endmodule

// File: tb/tb_keylink_top.sv
module tb_keylink_top;

  localparam int  CLK_PERIOD = 10;
  localparam int  KEYS       = 30;
  localparam int  FRAME      = 32;
  localparam int  WATCHDOG   = 100000;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [KEYS-1:0] keys_in = '0;
  logic [KEYS-1:0] keys_out;
  logic            link_load_n, link_latch, link_data;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  logic [KEYS-1:0] prev_out = '0;

  keylink_top dut (
    .clk (clk), .rst (rst), .keys_in (keys_in), .keys_out (keys_out),
    .link_load_n (link_load_n), .link_latch (link_latch), .link_data (link_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected at most %0d", cycles, WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // Leaves the bench at the negedge inside state 0.
  task automatic to_frame_start();
    while (!link_latch) @(negedge clk);
    while (link_latch)  @(negedge clk);
  endtask

  // Walks states 0..31; optionally checks data bits against pat.
  task automatic run_frame(input bit chk_data, input logic [KEYS-1:0] pat);
    for (int p = 0; p < FRAME; p++) begin
      logic expb;
      expb = (p < KEYS) ? pat[KEYS-1-p] : 1'b0;
      if (chk_data) begin
        if (p < KEYS) chk(link_data == expb, "R3 data bit", 32'(link_data), 32'(expb));
        else          chk(link_data == 1'b0, "R4 padding", 32'(link_data), 32'd0);
      end
      chk(keys_out == prev_out, "R5 hold", 32'(keys_out), 32'(prev_out));
      chk(link_latch == 1'b0, "R2 latch low in shift", 32'(link_latch), 32'd0);
      @(negedge clk);
    end
  endtask

  task automatic send(input logic [KEYS-1:0] pat);
    to_frame_start();
    keys_in = pat;          // mid-stream change, must not disturb keys_out
    run_frame(1'b0, '0);
    to_frame_start();
    run_frame(1'b1, pat);
    to_frame_start();
    chk(keys_out == pat, "R6 key arrival", 32'(keys_out), 32'(pat));
    prev_out = pat;
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk(keys_out == '0, "R7 reset keys_out", 32'(keys_out), 32'd0);
    chk(link_latch == 1'b0, "R7 reset latch", 32'(link_latch), 32'd0);
    chk(link_load_n == 1'b1, "R7 reset load_n", 32'(link_load_n), 32'd1);
    rst = 1'b0;

    // R7: strobe rises 32 clocks after release.
    n = 0;
    while (!link_latch) begin n++; @(negedge clk); end
    chk(n == FRAME, "R7 first strobe", 32'(n), 32'(FRAME));

    // R2: strobe width, R1: period.
    n = 0;
    while (link_latch) begin
      chk(link_load_n == 1'b0, "R2 load_n inverse", 32'(link_load_n), 32'd0);
      n++; @(negedge clk);
    end
    chk(n == 2, "R2 strobe width", 32'(n), 32'd2);
    chk(keys_out == '0, "R7 first frame zero", 32'(keys_out), 32'd0);
    n = 0;
    while (!link_latch) begin n++; @(negedge clk); end
    while (link_latch)  begin n++; @(negedge clk); end
    chk(n == FRAME + 2, "R1 frame period", 32'(n), 32'(FRAME + 2));

    // Sweep: dense patterns then every single key.
    send('1);
    send(30'h2AAA_AAAA);
    send(30'h1555_5555);
    send('0);
    for (int k = 0; k < KEYS; k++) send(KEYS'(1) << k);
    send(30'h3F00_00FF);

    // R7: reset mid-frame clears outputs and restarts the count.
    to_frame_start();
    repeat (7) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(keys_out == '0, "R7 mid reset keys_out", 32'(keys_out), 32'd0);
    chk(link_latch == 1'b0, "R7 mid reset latch", 32'(link_latch), 32'd0);
    keys_in = '0;
    @(negedge clk);
    rst = 1'b0;
    n = 0;
    while (!link_latch) begin n++; @(negedge clk); end
    chk(n == FRAME, "R7 restart strobe", 32'(n), 32'(FRAME));
    prev_out = '0;
    send(30'h0123_4567);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule